// File: doc/BRIEF.md
# Pattern Generator Pin Output Stage

This block sits between a stream of pattern words and a bank of bidirectional pins. It consumes one word from the pattern source every (divider + 1) cycles on which the source marks its data valid, and holds that word on the pins until the next one is taken. A read strobe tells the source each time a word has been consumed. Invalid cycles neither advance the pacing count nor consume data, so the source can stall freely.

Each pin can be driven from the held pattern word or from a fixed override value, selected per pin by a mask. A per-pin direction setting releases a pin entirely. A global mode selects push-pull drive or open-drain emulation. In open-drain mode an output pin carrying a 1 is released rather than driven high. The pin settings are captured into registers on each clock, so a change takes effect one cycle after it is presented. Reset leaves every pin released.

Top module: `pgen_pin_stage`

## Requirements
- R1: After reset the held word is all zeros, every pin release line is 1, and the read strobe is 0.
- R2: The read strobe is high for a cycle only when the pattern valid input is high in that cycle and the pace count has reached the divider. With divider 0 it is high on every valid cycle.
- R3: With a fixed divider D and the count at zero, the strobe fires on every (D+1)-th valid cycle. Cycles with valid low do not advance the count.
- R4: The held word loads the pattern data present in a strobe cycle at the clock edge that ends it, and it is unchanged at every other edge.
- R5: A pin whose override mask bit is 1 outputs the matching override data bit. A pin whose mask bit is 0 outputs the held word bit.
- R6: A pin whose direction bit is 1 (input) has its release line at 1, whatever its data and the output mode.
- R7: In output mode 0 (push-pull), every pin with direction bit 0 has its release line at 0.
- R8: In output mode 1 (open-drain), a pin with direction bit 0 is released when its output value is 1 and driven when its output value is 0. A pin is never driven high.
- R9: Direction, override mask, override data and output mode take effect at the pins one clock after they are presented.
- R10: If the divider is lowered to or below the current count, the next valid cycle fires the strobe and restarts the count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| patData | input | PIN_COUNT | Pattern word from the source |
| patValid | input | 1 | Pattern word valid |
| divider | input | DIV_W | Consume one word per divider+1 valid cycles |
| pinDir | input | PIN_COUNT | Per-pin direction, 1 = input (released) |
| ovMask | input | PIN_COUNT | Per-pin override select |
| ovData | input | PIN_COUNT | Per-pin override value |
| odMode | input | 1 | 0 = push-pull, 1 = open-drain |
| pinOut | output | PIN_COUNT | Pin output values |
| pinRelease | output | PIN_COUNT | Per-pin tristate select, 1 = released |
| readStrobe | output | 1 | Word consumed this cycle |

## Verification
A wrong pace count shows at the read strobe within one valid cycle: the strobe fires on the wrong valid cycle of a (D+1) period. It also shows one cycle later as a held word that changes too early or stays stale on the pins. A corrupted held word or override register appears at pinOut the cycle after it is written. A wrong direction or mode register appears on pinRelease at the same point, and in open-drain mode it can show as a pin driven while carrying a 1. The bench therefore samples every output on each cycle around a strobe. It does not wait for long runs to expose these faults.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  typedef struct packed {
    logic loadWord;
  } pgenCtl_t;
endpackage

// File: rtl/pgen_pace_ctrl.sv
module pgen_pace_ctrl #(
  parameter int DIV_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               patValid,
  input  logic [DIV_W-1:0]   divider,
  output pgen_pkg::pgenCtl_t ctl,
  output logic               readStrobe
);
  logic [DIV_W-1:0] paceCnt;
  logic             expired;

  assign expired        = (paceCnt >= divider);
  assign readStrobe     = patValid && expired;
  assign ctl.loadWord   = readStrobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      paceCnt <= '0;
    end else if (patValid) begin
      if (expired) paceCnt <= '0;
      else         paceCnt <= paceCnt + 1'b1;
    end
  end

  AST_STROBE_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    readStrobe |=> (paceCnt == '0)); // R10
  AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    !patValid |=> $stable(paceCnt)); // R3
endmodule

// File: rtl/pgen_pin_datapath.sv
module pgen_pin_datapath #(
  parameter int PIN_COUNT = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pgen_pkg::pgenCtl_t   ctl,
  input  logic [PIN_COUNT-1:0] patData,
  input  logic [PIN_COUNT-1:0] pinDir,
  input  logic [PIN_COUNT-1:0] ovMask,
  input  logic [PIN_COUNT-1:0] ovData,
  input  logic                 odMode,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinRelease
);
  logic [PIN_COUNT-1:0] heldWord;
  logic [PIN_COUNT-1:0] dirReg, maskReg, ovReg;
  logic                 odReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldWord <= '0;
      dirReg   <= '1;
      maskReg  <= '0;
      ovReg    <= '0;
      odReg    <= 1'b0;
    end else begin
      if (ctl.loadWord) heldWord <= patData;
      dirReg  <= pinDir;
      maskReg <= ovMask;
      ovReg   <= ovData;
      odReg   <= odMode;
    end
  end

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    always_comb begin
      pinOut[i]     = maskReg[i] ? ovReg[i] : heldWord[i];
      pinRelease[i] = dirReg[i] | (odReg & pinOut[i]);
    end
  end

  AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadWord |=> $stable(heldWord)); // R4
  AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (dirReg & ~pinRelease) == '0); // R6
  AST_NEVER_DRIVE_HIGH_OD: assert property (@(posedge clk) disable iff (!rstN)
    odReg |-> ((~pinRelease & pinOut) == '0)); // R8
endmodule

// File: rtl/pgen_pin_stage.sv
module pgen_pin_stage #(
  parameter int PIN_COUNT = 16,
  parameter int DIV_W     = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIN_COUNT-1:0] patData,
  input  logic                 patValid,
  input  logic [DIV_W-1:0]     divider,
  input  logic [PIN_COUNT-1:0] pinDir,
  input  logic [PIN_COUNT-1:0] ovMask,
  input  logic [PIN_COUNT-1:0] ovData,
  input  logic                 odMode,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinRelease,
  output logic                 readStrobe
);
  pgen_pkg::pgenCtl_t ctl;

  pgen_pace_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .patValid(patValid), .divider(divider),
    .ctl(ctl), .readStrobe(readStrobe)
  );

  pgen_pin_datapath #(.PIN_COUNT(PIN_COUNT)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .patData(patData),
    .pinDir(pinDir), .ovMask(ovMask), .ovData(ovData), .odMode(odMode),
    .pinOut(pinOut), .pinRelease(pinRelease)
  );

  AST_STROBE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    readStrobe |-> patValid); // R2
endmodule

// File: tb/tb_pgen_pin_stage.sv
module tb_pgen_pin_stage;
  localparam int CLK_PERIOD = 10;
  localparam int N = 7;
  // fields: word, mask, ovData, dir, mode, expected out, expected release
  localparam logic [16*6+1-1:0] VEC [N] = '{
    {16'hA5A5, 16'h0000, 16'h0000, 16'h0000, 1'b0, 16'hA5A5, 16'h0000},
    {16'hA5A5, 16'h00FF, 16'h1234, 16'h0000, 1'b0, 16'hA534, 16'h0000},
    {16'hFFFF, 16'h0000, 16'h0000, 16'hF0F0, 1'b0, 16'hFFFF, 16'hF0F0},
    {16'h0F0F, 16'h0000, 16'h0000, 16'h0000, 1'b1, 16'h0F0F, 16'h0F0F},
    {16'h3C3C, 16'hFF00, 16'h8100, 16'h000F, 1'b1, 16'h813C, 16'h813F},
    {16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0, 16'hFFFF, 16'h0000},
    {16'h5555, 16'h0000, 16'h0000, 16'hFFFF, 1'b1, 16'h5555, 16'hFFFF}
  };

  logic clk = 0, rstN = 0;
  logic [15:0] patData = '0, pinDir = '0, ovMask = '0, ovData = '0;
  logic patValid = 0, odMode = 0;
  logic [31:0] divider = '0;
  logic [15:0] pinOut, pinRelease;
  logic readStrobe;
  int errors = 0, checks = 0;
  logic [15:0] expWord;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgen_pin_stage dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 word", pinOut, 16'h0000);
    chk("R1 release", pinRelease, 16'hFFFF);
    chk("R1 strobe", readStrobe, 0);
    rstN = 1;

    for (int v = 0; v < N; v++) begin
      @(negedge clk);
      {patData, ovMask, ovData, pinDir, odMode} = VEC[v][16*6:32];
      patValid = 1;
      #1 chk("R2 div0 strobe", readStrobe, 1);
      @(negedge clk);
      patValid = 0;
      #1;
      chk($sformatf("R5 R8 vec%0d out", v), pinOut, VEC[v][31:16]);
      chk($sformatf("R6 R7 R8 vec%0d release", v), pinRelease, VEC[v][15:0]);
    end

    // R9: settings land one clock later
    @(negedge clk);
    pinDir = 16'h0000; ovMask = 0; odMode = 0;
    @(negedge clk);
    pinDir = 16'h00FF;
    #1 chk("R9 before edge", pinRelease, 16'h0000);
    @(negedge clk);
    chk("R9 after edge", pinRelease, 16'h00FF);
    pinDir = 16'h0000;

    // R3/R4: divider 2, continuous valid
    divider = 2;
    expWord = 16'h5555;
    @(negedge clk);
    for (int k = 0; k < 9; k++) begin
      chk("R4 hold", pinOut, expWord);
      patData = 16'h1000 + 16'(k);
      patValid = 1;
      #1 chk($sformatf("R3 strobe k=%0d", k), readStrobe, (k % 3) == 2);
      if ((k % 3) == 2) expWord = patData;
      @(negedge clk);
    end
    chk("R4 last load", pinOut, 16'h1008);

    // R3: invalid cycles do not count, no strobe
    patValid = 0;
    for (int k = 0; k < 3; k++) begin
      patData = 16'hBEEF;
      #1 chk("R2 no strobe when idle", readStrobe, 0);
      @(negedge clk);
      chk("R4 idle hold", pinOut, 16'h1008);
    end
    patValid = 1; patData = 16'h2001;
    #1 chk("R3 gap count1", readStrobe, 0);
    @(negedge clk);
    #1 chk("R3 gap count2", readStrobe, 0);
    @(negedge clk);
    divider = 5;
    #1 chk("R3 raised divider", readStrobe, 0);
    @(negedge clk);
    #1 chk("R3 raised divider 2", readStrobe, 0);
    @(negedge clk);
    // count is now 4; lower divider below it
    divider = 1; patData = 16'h7E57;
    #1 chk("R10 lowered divider fires", readStrobe, 1);
    @(negedge clk);
    #1 chk("R10 count restarted", readStrobe, 0);
    chk("R10 word loaded", pinOut, 16'h7E57);
    @(negedge clk);
    #1 chk("R10 next period", readStrobe, 1);
    @(negedge clk);
    patValid = 0;

    // R1: reset again mid-run
    rstN = 0;
    #1;
    chk("R1 reset word", pinOut, 16'h0000);
    chk("R1 reset release", pinRelease, 16'hFFFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule